// File: doc/BRIEF.md
# Chained Address Window Decoder

This block turns a 20-bit nibble address into one of five region selects: a 64-nibble I/O register window, main RAM, two plug-in card slots and a ROM that is always present behind everything else. The four movable windows start out unassigned. Software places them one at a time, in a fixed chain order, by issuing configure commands on a shared data bus. The I/O window takes a single value, its base. Each memory window takes two values: first a size mask, then a base.

An unconfigure command releases the first assigned window, in chain order, whose base equals the command value. An ID value reports which module the next configure command will fill, and whether it expects a size or a base. For memory windows, address bits 11..0 are ignored. Bits 19..12 are compared against the base only where the mask holds a 1. Overlapping windows are resolved by a fixed priority. Writes that reach only the ROM raise no select and set a read-only fault flag instead.

Top module: `addr_window_ctrl`

## Requirements
- R1: After reset no window is assigned, every read selects the ROM (sel_o = 5'b10000), and id_o reads 0x00019.
- R2: Configure strobes fill the modules in chain order: I/O (one value, the base), then RAM, then card 1, then card 2. Each of the last three takes a size mask first and a base second.
- R3: The I/O window matches when bus_addr_i[19:6] equals base[19:6], so it spans 64 nibbles. It selects sel_o bit 0.
- R4: A memory window matches when bus_addr_i[19:12] equals base[19:12] in every bit where mask[19:12] is 1. RAM drives sel_o bit 1, card 1 drives bit 2, card 2 drives bit 3 and the ROM drives bit 4.
- R5: When windows overlap, at most one select is active, chosen in the order I/O, RAM, card 2, card 1, ROM.
- R6: An unconfigure strobe with value v releases the first assigned module in chain order whose stored base equals v. If no base matches, nothing is released. In either case the size-or-base step returns to the size step.
- R7: id_o[7:0] is 0x19 while the I/O window is pending. It is 0x03/0xF4 for RAM, 0x05/0xF6 for card 1 and 0x07/0xF8 for card 2, for the size step and the base step respectively. While a memory module is pending, id_o[19:8] holds that module's stored size bits 19..8; while I/O is pending those bits are 0. id_o is 0 once every module is assigned.
- R8: A configure strobe is ignored once every module is assigned. When configure and unconfigure strobe in the same cycle, only the unconfigure acts.
- R9: A write (bus_wr_i = 1) that hits no movable window gives sel_o = 0 and ro_fault_o = 1. A read of the same address selects the ROM with ro_fault_o = 0.
- R10: Values are captured on the clock edge that samples the strobe. Decoding uses the old assignment until that edge and the new one after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configure strobe |
| uncfg_valid_i | input | 1 | Unconfigure strobe |
| cmd_data_i | input | 20 | Size, base or release value carried by the strobe |
| bus_addr_i | input | 20 | Nibble address to decode |
| bus_wr_i | input | 1 | Access is a write |
| sel_o | output | 5 | One-hot select: bit0 I/O, bit1 RAM, bit2 card 1, bit3 card 2, bit4 ROM |
| ro_fault_o | output | 1 | Write hit only the ROM or unmapped space |
| id_o | output | 20 | Pending module identifier |

## Verification
The hardest state to reach is a release that arrives while a memory module sits between its size step and its base step. That release must drop the chain back to a size step for whichever module is now first unassigned, which may be a different module. The stimulus reaches it by filling every module, releasing RAM, sending one new size value and then releasing card 1. The ID must then show RAM again, at its size step, with the newly stored size in the upper bits. Overlap priority is reached by placing card 2 inside card 1 and, later, placing I/O inside RAM and card 2 over I/O.

// File: rtl/addr_window_pkg.sv
package addr_window_pkg;
  localparam int ADDR_W   = 20;
  localparam int N_MEM    = 3;   // ram, card1, card2 in chain order
  localparam int IO_LSB   = 6;
  localparam int PAGE_LSB = 12;
  localparam int ID_LSB   = 8;
  localparam int N_SEL    = N_MEM + 2;

  localparam logic [7:0] ID_IO = 8'h19;

  function automatic logic [7:0] id_size_code(input int idx);
    return 8'(8'h03 + 2 * idx);
  endfunction

  function automatic logic [7:0] id_base_code(input int idx);
    return 8'(8'hF4 + 2 * idx);
  endfunction

  typedef enum logic [2:0] {
    SEL_IO    = 3'd0,
    SEL_RAM   = 3'd1,
    SEL_CARD1 = 3'd2,
    SEL_CARD2 = 3'd3,
    SEL_ROM   = 3'd4
  } sel_idx_e;
endpackage

// File: rtl/awc_cfg_chain.sv
module awc_cfg_chain
  import addr_window_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int NM    = N_MEM,
  parameter int ID_LS = ID_LSB
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_i,
  input  logic                   uncfg_i,
  input  logic [AW-1:0]          data_i,
  output logic                   io_vld_o,
  output logic [AW-1:0]          io_base_o,
  output logic [NM-1:0]          mem_vld_o,
  output logic [NM-1:0][AW-1:0]  mem_base_o,
  output logic [NM-1:0][AW-1:0]  mem_mask_o,
  output logic [AW-1:0]          id_o
);
  localparam int N_MOD = NM + 1;
  localparam int IDX_W = $clog2(N_MOD + 1);
  localparam logic [IDX_W-1:0] IDX_NONE = IDX_W'(N_MOD);

  logic                  io_vld_q;
  logic [AW-1:0]         io_base_q;
  logic [NM-1:0]         mem_vld_q;
  logic [NM-1:0][AW-1:0] mem_base_q, mem_mask_q;
  logic                  base_step_q;

  logic [N_MOD-1:0]          vld_all;
  logic [N_MOD-1:0][AW-1:0]  base_all;
  logic [IDX_W-1:0]          pend;
  logic [N_MOD-1:0]          rel_hit;

  assign vld_all  = {mem_vld_q, io_vld_q};
  assign base_all = {mem_base_q, io_base_q};

  // first unassigned module in chain order
  always_comb begin
    pend = IDX_NONE;
    for (int i = N_MOD - 1; i >= 0; i--)
      if (!vld_all[i]) pend = IDX_W'(i);
  end

  // first assigned module whose base equals the release value
  always_comb begin
    logic found;
    found   = 1'b0;
    rel_hit = '0;
    for (int i = 0; i < N_MOD; i++) begin
      if (!found && vld_all[i] && base_all[i] == data_i) begin
        rel_hit[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_vld_q    <= 1'b0;
      io_base_q   <= '0;
      mem_vld_q   <= '0;
      mem_base_q  <= '0;
      mem_mask_q  <= '0;
      base_step_q <= 1'b0;
    end else if (uncfg_i) begin
      base_step_q <= 1'b0;
      if (rel_hit[0]) io_vld_q <= 1'b0;
      for (int i = 0; i < NM; i++)
        if (rel_hit[i+1]) mem_vld_q[i] <= 1'b0;
    end else if (cfg_i && pend != IDX_NONE) begin
      if (pend == '0) begin
        io_base_q <= data_i;
        io_vld_q  <= 1'b1;
      end
      for (int i = 0; i < NM; i++) begin
        if (pend == IDX_W'(i + 1)) begin
          if (!base_step_q) begin
            mem_mask_q[i] <= data_i;
            base_step_q   <= 1'b1;
          end else begin
            mem_base_q[i] <= data_i;
            mem_vld_q[i]  <= 1'b1;
            base_step_q   <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    id_o = '0;
    if (pend == '0) id_o[7:0] = ID_IO;
    for (int i = 0; i < NM; i++) begin
      if (pend == IDX_W'(i + 1))
        id_o = {mem_mask_q[i][AW-1:ID_LS],
                base_step_q ? id_base_code(i) : id_size_code(i)};
    end
  end

  assign io_vld_o   = io_vld_q;
  assign io_base_o  = io_base_q;
  assign mem_vld_o  = mem_vld_q;
  assign mem_base_o = mem_base_q;
  assign mem_mask_o = mem_mask_q;
endmodule

// File: rtl/awc_win_match.sv
module awc_win_match #(
  parameter int AW  = 20,
  parameter int LSB = 12
) (
  input  logic          vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  output logic          hit_o
);
  logic [AW-1:0] diff;
  assign diff  = (addr_i ^ base_i) & mask_i;
  assign hit_o = vld_i && ((diff >> LSB) == '0);
endmodule

// File: rtl/awc_prio_sel.sv
module awc_prio_sel #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,   // bit 0 highest priority
  output logic [N-1:0] gnt_o,
  output logic         none_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) gnt_o = N'(1) << i;
  end
  assign none_o = (req_i == '0);
endmodule

// File: rtl/addr_window_ctrl.sv
module addr_window_ctrl
  import addr_window_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic              uncfg_valid_i,
  input  logic [ADDR_W-1:0] cmd_data_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  output logic [N_SEL-1:0]  sel_o,
  output logic              ro_fault_o,
  output logic [ADDR_W-1:0] id_o
);
  localparam int N_REQ = N_MEM + 1;

  logic                          io_vld;
  logic [ADDR_W-1:0]             io_base;
  logic [N_MEM-1:0]              mem_vld;
  logic [N_MEM-1:0][ADDR_W-1:0]  mem_base, mem_mask;
  logic                          io_hit;
  logic [N_MEM-1:0]              mem_hit;
  logic [N_REQ-1:0]              req, gnt;
  logic                          none;

  awc_cfg_chain #(.AW(ADDR_W), .NM(N_MEM), .ID_LS(ID_LSB)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg_valid_i),
    .uncfg_i    (uncfg_valid_i),
    .data_i     (cmd_data_i),
    .io_vld_o   (io_vld),
    .io_base_o  (io_base),
    .mem_vld_o  (mem_vld),
    .mem_base_o (mem_base),
    .mem_mask_o (mem_mask),
    .id_o       (id_o)
  );

  awc_win_match #(.AW(ADDR_W), .LSB(IO_LSB)) u_io_match (
    .vld_i  (io_vld),
    .addr_i (bus_addr_i),
    .base_i (io_base),
    .mask_i ({ADDR_W{1'b1}}),
    .hit_o  (io_hit)
  );

  for (genvar g = 0; g < N_MEM; g++) begin : g_mem
    awc_win_match #(.AW(ADDR_W), .LSB(PAGE_LSB)) u_match (
      .vld_i  (mem_vld[g]),
      .addr_i (bus_addr_i),
      .base_i (mem_base[g]),
      .mask_i (mem_mask[g]),
      .hit_o  (mem_hit[g])
    );
  end

  // priority order: io, ram, card2, card1
  assign req = {mem_hit[1], mem_hit[2], mem_hit[0], io_hit};

  awc_prio_sel #(.N(N_REQ)) u_prio (
    .req_i  (req),
    .gnt_o  (gnt),
    .none_o (none)
  );

  always_comb begin
    sel_o            = '0;
    sel_o[SEL_IO]    = gnt[0];
    sel_o[SEL_RAM]   = gnt[1];
    sel_o[SEL_CARD2] = gnt[2];
    sel_o[SEL_CARD1] = gnt[3];
    sel_o[SEL_ROM]   = none && !bus_wr_i;
  end

  assign ro_fault_o = none && bus_wr_i;
endmodule

// File: rtl/awc_checker.sv
module awc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_valid_i,
  input logic        uncfg_valid_i,
  input logic        bus_wr_i,
  input logic [4:0]  sel_o,
  input logic        ro_fault_o,
  input logic [19:0] id_o
);
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R5

  AST_RO_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_fault_o |-> (bus_wr_i && sel_o == 5'b0)); // R9

  AST_READ_SELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_i |-> ($countones(sel_o) == 1 && !ro_fault_o)); // R9

  AST_IO_PEND_NO_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_o[7:0] == 8'h19) |-> !sel_o[0]); // R2

  AST_RELEASE_SIZE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(uncfg_valid_i) |-> (id_o[7:0] == 8'h19 || id_o[7:0] == 8'h03 ||
                              id_o[7:0] == 8'h05 || id_o[7:0] == 8'h07 ||
                              id_o == 20'h0)); // R6

  AST_FULL_IGNORES_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_o == 20'h0 && cfg_valid_i && !uncfg_valid_i) |=> (id_o == 20'h0)); // R8
endmodule

bind addr_window_ctrl awc_checker u_awc_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_valid_i   (cfg_valid_i),
  .uncfg_valid_i (uncfg_valid_i),
  .bus_wr_i      (bus_wr_i),
  .sel_o         (sel_o),
  .ro_fault_o    (ro_fault_o),
  .id_o          (id_o)
);

// File: tb/addr_window_ctrl_test.sv
module addr_window_ctrl_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] S_IO = 5'b00001, S_RAM = 5'b00010, S_C1 = 5'b00100,
                         S_C2 = 5'b01000, S_ROM = 5'b10000, S_NONE = 5'b00000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_valid_i = 1'b0;
  logic        uncfg_valid_i = 1'b0;
  logic [19:0] cmd_data_i = '0;
  logic [19:0] bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [4:0]  sel_o;
  logic        ro_fault_o;
  logic [19:0] id_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  addr_window_ctrl uut (
    .clk_i, .rst_ni, .cfg_valid_i, .uncfg_valid_i, .cmd_data_i,
    .bus_addr_i, .bus_wr_i, .sel_o, .ro_fault_o, .id_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_cmd(input logic [19:0] v);
    @(negedge clk_i); cmd_data_i = v; cfg_valid_i = 1'b1;
    @(negedge clk_i); cfg_valid_i = 1'b0;
  endtask

  task automatic uncfg_cmd(input logic [19:0] v);
    @(negedge clk_i); cmd_data_i = v; uncfg_valid_i = 1'b1;
    @(negedge clk_i); uncfg_valid_i = 1'b0;
  endtask

  task automatic look(input string tag, input logic [19:0] a, input logic wr,
                      input logic [4:0] exp_sel, input logic exp_ro);
    @(negedge clk_i); bus_addr_i = a; bus_wr_i = wr; #2;
    check({tag, " sel"}, 32'(sel_o), 32'(exp_sel));
    check({tag, " ro"}, 32'(ro_fault_o), 32'(exp_ro));
  endtask

  task automatic chk_id(input string tag, input logic [19:0] exp);
    @(negedge clk_i); #2;
    check({tag, " id"}, 32'(id_o), 32'(exp));
  endtask

  task automatic t_reset();
    chk_id("R1 reset", 20'h00019);
    look("R1 read any", 20'h12345, 1'b0, S_ROM, 1'b0);
    look("R1 read io base", 20'h00100, 1'b0, S_ROM, 1'b0);
    look("R9 write rom", 20'h00000, 1'b1, S_NONE, 1'b1);
  endtask

  task automatic t_capture_timing();
    @(negedge clk_i);
    bus_addr_i = 20'h00100; bus_wr_i = 1'b0; cmd_data_i = 20'h00100; cfg_valid_i = 1'b1;
    #2 check("R10 before edge", 32'(sel_o), 32'(S_ROM));
    @(negedge clk_i); cfg_valid_i = 1'b0;
    #2 check("R10 after edge", 32'(sel_o), 32'(S_IO));
  endtask

  task automatic t_fill_chain();
    chk_id("R7 ram size pending", 20'h00003);
    look("R3 io top", 20'h0013F, 1'b0, S_IO, 1'b0);
    look("R3 io above", 20'h00140, 1'b0, S_ROM, 1'b0);
    look("R3 io below", 20'h000FF, 1'b0, S_ROM, 1'b0);
    cfg_cmd(20'hF0000);
    chk_id("R7 ram base pending", 20'hF00F4);
    look("R2 ram not yet", 20'h80000, 1'b0, S_ROM, 1'b0);
    cfg_cmd(20'h80000);
    chk_id("R7 card1 size pending", 20'h00005);
    look("R4 ram in", 20'h8ABCD, 1'b0, S_RAM, 1'b0);
    look("R4 ram edge", 20'h8FFFF, 1'b0, S_RAM, 1'b0);
    look("R4 ram out", 20'h90000, 1'b0, S_ROM, 1'b0);
    cfg_cmd(20'hC0000);
    chk_id("R7 card1 base pending", 20'hC00F6);
    cfg_cmd(20'h40000);
    chk_id("R7 card2 size pending", 20'h00007);
    look("R4 card1 wide", 20'h75555, 1'b0, S_C1, 1'b0);
    cfg_cmd(20'hF0000);
    chk_id("R7 card2 base pending", 20'hF00F8);
    cfg_cmd(20'h50000);
    chk_id("R7 all done", 20'h00000);
    look("R5 card2 over card1", 20'h55555, 1'b0, S_C2, 1'b0);
    look("R5 card1 outside card2", 20'h45555, 1'b0, S_C1, 1'b0);
    look("R9 write ram", 20'h80000, 1'b1, S_RAM, 1'b0);
    look("R9 write unmapped", 20'h12345, 1'b1, S_NONE, 1'b1);
    look("R9 read unmapped", 20'h12345, 1'b0, S_ROM, 1'b0);
  endtask

  task automatic t_full_ignore();
    cfg_cmd(20'h12000);
    chk_id("R8 extra cfg id", 20'h00000);
    look("R8 extra cfg no window", 20'h12000, 1'b0, S_ROM, 1'b0);
    look("R8 card1 kept", 20'h45555, 1'b0, S_C1, 1'b0);
  endtask

  task automatic t_release();
    uncfg_cmd(20'h50000);
    chk_id("R6 card2 released", 20'hF0007);
    look("R6 card2 gone", 20'h55555, 1'b0, S_C1, 1'b0);
    uncfg_cmd(20'h99999);
    chk_id("R6 no match", 20'hF0007);
    look("R6 ram kept", 20'h80000, 1'b0, S_RAM, 1'b0);
    cfg_cmd(20'hFF000);
    cfg_cmd(20'h00000);
    look("R5 io over card2", 20'h00100, 1'b0, S_IO, 1'b0);
    look("R5 card2 page", 20'h00200, 1'b0, S_C2, 1'b0);
    uncfg_cmd(20'h00100);
    chk_id("R6 io released", 20'h00019);
    look("R6 io gone", 20'h00100, 1'b0, S_C2, 1'b0);
    cfg_cmd(20'h80040);
    look("R5 io over ram", 20'h80050, 1'b0, S_IO, 1'b0);
    look("R3 ram beside io", 20'h80000, 1'b0, S_RAM, 1'b0);
  endtask

  task automatic t_release_mid_step();
    uncfg_cmd(20'h80000);
    chk_id("R6 ram released", 20'hF0003);
    cfg_cmd(20'hFF000);
    chk_id("R7 ram base step", 20'hFF0F4);
    uncfg_cmd(20'h40000);
    chk_id("R6 step cleared", 20'hFF003);
    look("R6 card1 gone", 20'h45555, 1'b0, S_ROM, 1'b0);
    cfg_cmd(20'hF0000);
    cfg_cmd(20'h80000);
    chk_id("R2 card1 next", 20'hC0005);
    cfg_cmd(20'hC0000);
    cfg_cmd(20'h40000);
    chk_id("R2 refilled", 20'h00000);
  endtask

  task automatic t_same_cycle();
    @(negedge clk_i);
    cmd_data_i = 20'h40000; cfg_valid_i = 1'b1; uncfg_valid_i = 1'b1;
    @(negedge clk_i); cfg_valid_i = 1'b0; uncfg_valid_i = 1'b0;
    chk_id("R8 release wins", 20'hC0005);
    look("R8 card1 released", 20'h45555, 1'b0, S_ROM, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_capture_timing();
    t_fill_chain();
    t_full_ignore();
    t_release();
    t_release_mid_step();
    t_same_cycle();
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule